// File: doc/BRIEF.md
# AHB Slave Access Forwarding Bridge

This block sits on a local AHB-Lite bus as a slave and turns every accepted access into a single command packet for a remote host. Each packet carries three fields: a command code, a byte address and a data word. Writes are posted. The block sends a write packet that carries the captured address and the write data, and it completes the bus transfer as soon as the packet is taken. It does not wait for any reply.

Reads are forwarded as a read-request packet whose data field is zero. The bus data phase is then stretched for as long as needed, until a read-acknowledge packet comes back on the input stream. The returned data is then placed on the read data bus. Only one read can be outstanding. Bursts are not supported, because every access is a separate NONSEQ transfer.

The block accepts an access only if its address falls inside a window whose base and size are set on input pins. An access outside the window is answered with the standard two-cycle ERROR response and produces no packet.

Top module: `ahbpkt_bridge`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0 and pkt_valid is 0.
- R2: A write accepted in the window produces one packet in its data phase with pkt_cmd = 8'h01, pkt_addr = the address from the address phase and pkt_data = hwdata. The transfer completes in the cycle the packet is taken, with an OKAY response.
- R3: A read accepted in the window produces one packet in its data phase with pkt_cmd = 8'h02, pkt_addr = the address from the address phase and pkt_data = 0.
- R4: After a read-request packet is taken, hreadyout stays 0 until an input packet with ack_cmd = 8'h03 is presented with ack_valid. In the next cycle hreadyout is 1, hresp is 0 and hrdata equals that packet's ack_data.
- R5: While a read waits, input packets with any ack_cmd other than 8'h03 have no effect: hreadyout stays 0 and the later matching acknowledge still supplies the read data.
- R6: While pkt_valid is 1 and pkt_ready is 0, hreadyout is 0 and pkt_cmd, pkt_addr and pkt_data stay unchanged.
- R7: A transfer with hsel 0, or with htrans IDLE (2'b00) or BUSY (2'b01), produces no packet and gets hreadyout 1 with hresp 0 (OKAY) in the next cycle.
- R8: A NONSEQ (2'b10) transfer whose address is outside the window produces no packet. Its data phase shows hresp 1 with hreadyout 0, then hresp 1 with hreadyout 1.
- R9: An address is inside the window when (haddr - win_base), taken modulo 2^AW, is less than win_size. So win_base + win_size - 1 is accepted, while win_base + win_size and win_base - 1 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_base | input | AW | First byte address of the accepted window |
| win_size | input | AW | Window size in bytes |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| haddr | input | AW | Transfer address |
| hwdata | input | DW | Write data (data phase) |
| hready | input | 1 | Bus-wide ready, qualifies the address phase |
| hreadyout | output | 1 | Data phase ready from this slave |
| hresp | output | 1 | 1 = ERROR response |
| hrdata | output | DW | Read data |
| pkt_valid | output | 1 | Outgoing packet valid |
| pkt_ready | input | 1 | Outgoing packet accepted |
| pkt_cmd | output | 8 | Outgoing command code |
| pkt_addr | output | AW | Outgoing address field |
| pkt_data | output | DW | Outgoing data field |
| ack_valid | input | 1 | Incoming packet valid (always consumed) |
| ack_cmd | input | 8 | Incoming command code |
| ack_data | input | DW | Incoming data field |

## Verification
A packet is due in the data phase, one clock after the address phase is sampled. The bench drives each address phase just after a rising edge and reads outputs at the following falling edge. A posted write can therefore complete in that first data-phase cycle, while an error shows its two response cycles on the two falling edges after the address phase. A read completes one cycle after the clock that samples the matching acknowledge, so the bench looks for hrdata at the falling edge after the acknowledge is withdrawn. Packets are compared by a monitor that pops the expected packet from a queue whenever pkt_valid and pkt_ready are both high at a falling edge.

// File: rtl/ahbpkt_pkg.sv
package ahbpkt_pkg;
    localparam int CMD_W = 8;
    localparam logic [CMD_W-1:0] CMD_SLV_WR     = 8'h01;
    localparam logic [CMD_W-1:0] CMD_SLV_RD     = 8'h02;
    localparam logic [CMD_W-1:0] CMD_SLV_RD_ACK = 8'h03;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SEND,
        ST_RD_SEND,
        ST_RD_WAIT,
        ST_RD_DONE,
        ST_ERR_1,
        ST_ERR_2
    } bridge_st_e;
endpackage

// File: rtl/ahbpkt_req_decode.sv
module ahbpkt_req_decode
    import ahbpkt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          hsel,
    input  logic [1:0]    htrans,
    input  logic          hready,
    input  logic [AW-1:0] haddr,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] win_size,
    output logic          start,
    output logic          in_window
);
    logic [AW-1:0] offset;

    always_comb begin
        offset    = haddr - win_base;
        in_window = (offset < win_size);
        start     = hsel && hready && (htrans == TR_NONSEQ);
    end
endmodule

// File: rtl/ahbpkt_ack_filter.sv
module ahbpkt_ack_filter
    import ahbpkt_pkg::*;
(
    input  logic             ack_valid,
    input  logic [CMD_W-1:0] ack_cmd,
    output logic             ack_hit
);
    always_comb begin
        ack_hit = ack_valid && (ack_cmd == CMD_SLV_RD_ACK);
    end
endmodule

// File: rtl/ahbpkt_ctrl.sv
module ahbpkt_ctrl
    import ahbpkt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             in_window,
    input  logic             hwrite,
    input  logic [AW-1:0]    haddr,
    input  logic [DW-1:0]    hwdata,
    input  logic             ack_hit,
    input  logic [DW-1:0]    ack_data,
    input  logic             pkt_ready,
    output logic             hreadyout,
    output logic             hresp,
    output logic [DW-1:0]    hrdata,
    output logic             pkt_valid,
    output logic [CMD_W-1:0] pkt_cmd,
    output logic [AW-1:0]    pkt_addr,
    output logic [DW-1:0]    pkt_data
);
    typedef struct packed {
        bridge_st_e    st;
        logic [AW-1:0] addr;
        logic [DW-1:0] rdata;
    } ctrl_regs_t;

    ctrl_regs_t r_q, r_d;
    logic       take_next;

    always_comb begin
        r_d       = r_q;
        take_next = 1'b0;
        hreadyout = 1'b1;
        hresp     = 1'b0;
        pkt_valid = 1'b0;
        pkt_cmd   = CMD_SLV_WR;
        pkt_data  = '0;

        case (r_q.st)
            ST_IDLE: begin
                take_next = 1'b1;
            end
            ST_WR_SEND: begin
                pkt_valid = 1'b1;
                pkt_cmd   = CMD_SLV_WR;
                pkt_data  = hwdata;
                hreadyout = pkt_ready;
                take_next = pkt_ready;
            end
            ST_RD_SEND: begin
                pkt_valid = 1'b1;
                pkt_cmd   = CMD_SLV_RD;
                hreadyout = 1'b0;
                if (pkt_ready) begin
                    r_d.st = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                hreadyout = 1'b0;
                if (ack_hit) begin
                    r_d.rdata = ack_data;
                    r_d.st    = ST_RD_DONE;
                end
            end
            ST_RD_DONE: begin
                take_next = 1'b1;
            end
            ST_ERR_1: begin
                hresp     = 1'b1;
                hreadyout = 1'b0;
                r_d.st    = ST_ERR_2;
            end
            ST_ERR_2: begin
                hresp     = 1'b1;
                take_next = 1'b1;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase

        if (take_next) begin
            r_d.st = ST_IDLE;
            if (start) begin
                if (in_window) begin
                    r_d.addr = haddr;
                    r_d.st   = hwrite ? ST_WR_SEND : ST_RD_SEND;
                end else begin
                    r_d.st   = ST_ERR_1;
                end
            end
        end

        pkt_addr = r_q.addr;
        hrdata   = r_q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, rdata: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R6: a stalled packet keeps its fields
    a_r6_pkt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_cmd) && $stable(pkt_addr)));

    // R4: a taken read request is followed by a stalled data phase
    a_r4_wait_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready && pkt_cmd == CMD_SLV_RD) |=> !hreadyout);

    // R4: matching acknowledge completes the read with its data next cycle
    a_r4_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RD_WAIT && ack_hit) |=> (hreadyout && !hresp && hrdata == $past(ack_data)));

    // R8: first error cycle is followed by the completing error cycle
    a_r8_err_second: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout));
endmodule

// File: rtl/ahbpkt_bridge.sv
module ahbpkt_bridge
    import ahbpkt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    win_base,
    input  logic [AW-1:0]    win_size,
    input  logic             hsel,
    input  logic [1:0]       htrans,
    input  logic             hwrite,
    input  logic [AW-1:0]    haddr,
    input  logic [DW-1:0]    hwdata,
    input  logic             hready,
    output logic             hreadyout,
    output logic             hresp,
    output logic [DW-1:0]    hrdata,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [CMD_W-1:0] pkt_cmd,
    output logic [AW-1:0]    pkt_addr,
    output logic [DW-1:0]    pkt_data,
    input  logic             ack_valid,
    input  logic [CMD_W-1:0] ack_cmd,
    input  logic [DW-1:0]    ack_data
);
    logic start;
    logic in_window;
    logic ack_hit;

    ahbpkt_req_decode #(.AW(AW)) u_decode (
        .hsel      (hsel),
        .htrans    (htrans),
        .hready    (hready),
        .haddr     (haddr),
        .win_base  (win_base),
        .win_size  (win_size),
        .start     (start),
        .in_window (in_window)
    );

    ahbpkt_ack_filter u_ack (
        .ack_valid (ack_valid),
        .ack_cmd   (ack_cmd),
        .ack_hit   (ack_hit)
    );

    ahbpkt_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .in_window (in_window),
        .hwrite    (hwrite),
        .haddr     (haddr),
        .hwdata    (hwdata),
        .ack_hit   (ack_hit),
        .ack_data  (ack_data),
        .pkt_ready (pkt_ready),
        .hreadyout (hreadyout),
        .hresp     (hresp),
        .hrdata    (hrdata),
        .pkt_valid (pkt_valid),
        .pkt_cmd   (pkt_cmd),
        .pkt_addr  (pkt_addr),
        .pkt_data  (pkt_data)
    );

    // R3: read requests carry a null data field
    a_r3_null_data: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_cmd == CMD_SLV_RD) |-> (pkt_data == '0));

    // R7: an idle or unselected address phase while ready gets OKAY with no packet
    a_r7_idle_okay: assert property (@(posedge clk) disable iff (!rst_n)
        (hreadyout && !hresp && hready && !(hsel && htrans == TR_NONSEQ)) |=> (hreadyout && !hresp && !pkt_valid));
endmodule

// File: tb/ahbpkt_bridge_bench.sv
module ahbpkt_bridge_bench;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam logic [AW-1:0] BASE = 32'h4000_0000;
    localparam logic [AW-1:0] SIZE = 32'h0000_0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsel = 1'b0;
    logic [1:0] htrans = 2'b00;
    logic hwrite = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [DW-1:0] hwdata = '0;
    logic hready;
    logic hreadyout, hresp;
    logic [DW-1:0] hrdata;
    logic pkt_valid;
    logic pkt_ready = 1'b1;
    logic [7:0] pkt_cmd;
    logic [AW-1:0] pkt_addr;
    logic [DW-1:0] pkt_data;
    logic ack_valid = 1'b0;
    logic [7:0] ack_cmd = '0;
    logic [DW-1:0] ack_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    logic [7+AW+DW:0] exp_q[$];

    always #5 clk = ~clk;
    assign hready = hreadyout;

    ahbpkt_bridge #(.AW(AW), .DW(DW)) u_ahbpkt_bridge (
        .clk(clk), .rst_n(rst_n), .win_base(BASE), .win_size(SIZE),
        .hsel(hsel), .htrans(htrans), .hwrite(hwrite), .haddr(haddr),
        .hwdata(hwdata), .hready(hready), .hreadyout(hreadyout),
        .hresp(hresp), .hrdata(hrdata), .pkt_valid(pkt_valid),
        .pkt_ready(pkt_ready), .pkt_cmd(pkt_cmd), .pkt_addr(pkt_addr),
        .pkt_data(pkt_data), .ack_valid(ack_valid), .ack_cmd(ack_cmd),
        .ack_data(ack_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor: every accepted packet is compared with the queue head
    always @(negedge clk) begin
        if (rst_n && pkt_valid && pkt_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8 unexpected packet", {pkt_cmd, pkt_addr[23:0], pkt_data}, 64'h0);
            end else begin
                logic [7+AW+DW:0] e;
                e = exp_q.pop_front();
                check({pkt_cmd, pkt_addr, pkt_data} == e, "R2/R3 packet",
                      {pkt_cmd, pkt_addr[23:0], pkt_data}, {e[7+AW+DW -: 8], e[DW+23:DW], e[DW-1:0]});
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic addr_phase(input bit wr, input logic [AW-1:0] a);
        step();
        hsel = 1'b1; htrans = 2'b10; hwrite = wr; haddr = a;
    endtask

    task automatic stall(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(hreadyout == 1'b0 && pkt_valid == 1'b1, "R6 stall", {hreadyout, pkt_valid}, 2'b01);
            step();
            check(pkt_valid == 1'b1, "R6 held", pkt_valid, 1);
        end
        pkt_ready = 1'b1;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n_stall);
        addr_phase(1'b1, a);
        exp_q.push_back({8'h01, a, d});
        step();
        hsel = 1'b0; htrans = 2'b00; hwdata = d; pkt_ready = (n_stall == 0);
        stall(n_stall);
        @(negedge clk);
        check(hreadyout == 1'b1 && hresp == 1'b0, "R2 write completes", {hreadyout, hresp}, 2'b10);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input int n_stall, input int n_bogus);
        addr_phase(1'b0, a);
        exp_q.push_back({8'h02, a, {DW{1'b0}}});
        step();
        hsel = 1'b0; htrans = 2'b00; pkt_ready = (n_stall == 0);
        stall(n_stall);
        step();
        for (int i = 0; i < n_bogus; i++) begin
            ack_valid = (i % 2 == 0); ack_cmd = (i % 3 == 0) ? 8'h01 : 8'h07; ack_data = 32'hDEAD_0000 + i;
            @(negedge clk);
            check(hreadyout == 1'b0, "R5 bogus ack ignored", hreadyout, 0);
            step();
        end
        ack_valid = 1'b1; ack_cmd = 8'h03; ack_data = d;
        @(negedge clk);
        check(hreadyout == 1'b0, "R4 still waiting", hreadyout, 0);
        step();
        ack_valid = 1'b0; ack_data = 32'hFFFF_FFFF;
        @(negedge clk);
        check(hreadyout == 1'b1 && hresp == 1'b0, "R4 read completes", {hreadyout, hresp}, 2'b10);
        check(hrdata == d, "R4 read data", hrdata, d);
    endtask

    task automatic do_bad(input bit wr, input logic [AW-1:0] a);
        addr_phase(wr, a);
        step();
        hsel = 1'b0; htrans = 2'b00;
        @(negedge clk);
        check(hresp == 1'b1 && hreadyout == 1'b0, "R8/R9 error cycle 1", {hresp, hreadyout}, 2'b10);
        step();
        @(negedge clk);
        check(hresp == 1'b1 && hreadyout == 1'b1, "R8/R9 error cycle 2", {hresp, hreadyout}, 2'b11);
    endtask

    task automatic do_idle(input bit sel, input logic [1:0] tr);
        step();
        hsel = sel; htrans = tr; hwrite = 1'b1; haddr = BASE + 4;
        step();
        hsel = 1'b0; htrans = 2'b00;
        @(negedge clk);
        check(hreadyout == 1'b1 && hresp == 1'b0 && pkt_valid == 1'b0, "R7 idle/busy okay",
              {hreadyout, hresp, pkt_valid}, 3'b100);
    endtask

    initial begin : watchdog
        #1_000_000;
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(hreadyout == 1'b1 && hresp == 1'b0 && pkt_valid == 1'b0, "R1 reset state",
              {hreadyout, hresp, pkt_valid}, 3'b100);
        #1 rst_n = 1'b1;

        do_write(BASE + 32'h10, 32'hA5A5_1234, 0);
        do_write(BASE + 32'h20, 32'h0BAD_F00D, 3);
        do_read(BASE + 32'h30, 32'h1357_9BDF, 0, 0);
        do_read(BASE + 32'h40, 32'h2468_ACE0, 2, 5);
        do_idle(1'b1, 2'b00);
        do_idle(1'b1, 2'b01);
        do_idle(1'b0, 2'b10);
        do_bad(1'b1, BASE + SIZE);
        do_bad(1'b0, BASE - 1);
        do_write(BASE + SIZE - 1, 32'h0000_00FF, 1);   // R9 top of window accepted
        do_read(BASE, 32'hCAFE_BEEF, 0, 1);              // R9 window base accepted
        do_bad(1'b0, 32'h0000_0000);

        step(); step();
        check(exp_q.size() == 0, "R2/R3 all packets seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule